// File: doc/BRIEF.md
# Linked-List Multi-Queue Manager

This block keeps four output-link queues and one pool of unused slots in a single shared slot memory. Each slot holds a 64-bit data word and a pointer to the slot that follows it. Each list is described by a first-slot pointer, a last-slot pointer and an occupancy count. Storing an item onto an output queue takes the first slot of the unused pool, writes the data into it and appends it to the chosen queue. Removing an item from an output queue unlinks that queue's first slot, returns the slot's data and appends the slot to the unused pool.

A requester offers one operation per cycle: a kind (store or remove), a queue number and, for a store, the data. Every accepted operation goes through two stages. In the first stage the list pointers are looked up. In the second stage the slot memory is accessed and the pointers are updated. Every accepted operation produces exactly one response carrying its kind, queue number, a refusal flag and, for a remove, the data. The first stage always sees the pointers as they stand after the operation ahead of it, so a remove that follows a store to an empty queue returns the item just stored. Two operations of the same kind are never accepted on consecutive cycles. The requester keeps the offending one on its inputs for an extra cycle.

Top module: `lnkq_mgr`

## Requirements
- R1: After reset `resp_valid` is 0 and `req_ready` is 1. All four output queues are empty. The unused pool holds all 32 slots, so exactly 32 stores succeed before any remove.
- R2: An accepted store (`req_deq`=0) that succeeds gives a response with `resp_deq`=0, `resp_err`=0, `resp_port` equal to the requested queue and `resp_data`=0.
- R3: A successful remove (`req_deq`=1) gives `resp_deq`=1, `resp_err`=0, `resp_port` equal to the queue, and `resp_data` equal to the oldest item still held in that queue (first-in, first-out).
- R4: An operation offered in cycle c and accepted at the clock edge that ends cycle c has its response on the outputs throughout cycle c+2. `resp_valid` is 0 in any cycle whose cycle c-2 had no accepted operation.
- R5: `req_ready` is 0 when `req_deq` equals the kind of the operation accepted in the previous cycle. While `req_ready` is 0 no operation is accepted. A held operation is accepted on the next cycle.
- R6: When store and remove requests alternate, `req_ready` stays 1 and one operation is accepted every cycle.
- R7: A store offered while the unused pool is empty is answered with `resp_err`=1 and `resp_data`=0, and changes no queue.
- R8: A remove from an empty output queue is answered with `resp_err`=1 and `resp_data`=0, and changes no queue.
- R9: Removing the last item of a queue leaves the queue empty, so a further remove is refused. A later store to that queue makes its item the queue's only item.
- R10: A removed item's slot returns to the unused pool, so after any sequence of operations the number of successful stores still possible equals 32 minus the items held in all output queues.
- R11: The four output queues are independent. Interleaved stores and removes on different queues keep each queue's own first-in, first-out order.
- R12: A remove accepted in the cycle right after a store to the same empty queue returns that store's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An operation is offered this cycle |
| req_deq | input | 1 | Operation kind: 0 store, 1 remove |
| req_queue | input | 2 | Target output queue 0 to 3 |
| req_data | input | 64 | Data for a store |
| req_ready | output | 1 | The offered kind may be accepted this cycle |
| resp_valid | output | 1 | A response is present |
| resp_deq | output | 1 | Kind of the answered operation |
| resp_err | output | 1 | The operation was refused |
| resp_port | output | 2 | Queue of the answered operation |
| resp_data | output | 64 | Removed data, 0 otherwise |

## Verification
Each response is due exactly two cycles after the cycle in which its request was offered and accepted. The bench drives inputs on the falling edge and decides acceptance from its own record of the previous cycle's accepted kind. It stores the expected response in a two-entry delay line that shifts once per falling edge, and compares the outputs against the entry that is leaving the line, so the comparison happens two falling edges after acceptance. `req_ready` is combinational and is checked in the same cycle, just after the inputs settle. Refusals, first-in first-out order, slot recycling and the store-then-remove bypass all fall out of a bench-side count and data model that is advanced at acceptance.

// File: rtl/lnkq_pkg.sv
// Package: shared types for the linked-list multi-queue manager.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lnkq_pkg;

    // Operation kind; the encoding matches the req_deq pin.
    typedef enum logic {
        OP_ENQ = 1'b0,
        OP_DEQ = 1'b1
    } lnkq_op_e;

endpackage

// File: rtl/lnkq_issue.sv
// Module: issue gate. Accepts at most one operation per cycle and refuses an
// operation whose kind equals the kind accepted in the previous cycle.
// Assumes: the requester holds a refused request on its inputs.
module lnkq_issue
    import lnkq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  lnkq_op_e req_kind,
    output logic     req_ready,
    output logic     accept
);

    logic     last_vld_q;
    lnkq_op_e last_kind_q;

    // Readiness: block a repeat of the kind accepted one cycle earlier.
    always_comb begin
        req_ready = !(last_vld_q && (last_kind_q == req_kind));
        accept    = req_valid && req_ready;
    end

    // History: remember whether and what was accepted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vld_q  <= 1'b0;
            last_kind_q <= OP_ENQ;
        end else begin
            last_vld_q <= accept;
            if (accept) begin
                last_kind_q <= req_kind;
            end
        end
    end

    // R5: two accepted operations in a row never share a kind.
    a_r5_kinds_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !(accept && (req_kind == $past(req_kind))));

endmodule

// File: rtl/lnkq_store.sv
// Module: slot memory. Holds one data word and one successor pointer per slot.
// Both are read combinationally at one address and written at the clock edge.
// Assumes: the data write and the pointer write never target the same slot in
// one cycle; at reset the successor pointers chain slot i to slot i+1.
module lnkq_store #(
    parameter int SLOTS = 32,
    parameter int PW    = 5,
    parameter int DW    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dat_we,
    input  logic [PW-1:0] dat_addr,
    input  logic [DW-1:0] dat_wdata,
    input  logic          lnk_we,
    input  logic [PW-1:0] lnk_addr,
    input  logic [PW-1:0] lnk_wdata,
    input  logic [PW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [PW-1:0] rd_link
);

    logic [DW-1:0] data_mem [SLOTS];
    logic [PW-1:0] link_mem [SLOTS];

    // Read port: data and successor of the addressed slot.
    always_comb begin
        rd_data = data_mem[rd_addr];
        rd_link = link_mem[rd_addr];
    end

    // Data array write; contents are undefined until first written.
    always_ff @(posedge clk) begin
        if (dat_we) begin
            data_mem[dat_addr] <= dat_wdata;
        end
    end

    // Successor array: reset to a chain through all slots, then linked on demand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                link_mem[i] <= PW'(i + 1);
            end
        end else if (lnk_we) begin
            link_mem[lnk_addr] <= lnk_wdata;
        end
    end

    // R10: a slot being filled is never the tail being relinked in the same cycle.
    a_r10_distinct_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && lnk_we) |-> (dat_addr != lnk_addr));

endmodule

// File: rtl/lnkq_ptrs.sv
// Module: list pointer table. Keeps first, last and count for every output
// list and for the unused pool (the highest list index). Applies one committed
// operation per cycle. The view outputs show the table after that commit, so
// the lookup stage sees the effect of the operation one stage ahead of it.
// Assumes: commits are never refused here; refusal is decided upstream.
module lnkq_ptrs
    import lnkq_pkg::*;
#(
    parameter int NL    = 5,
    parameter int SLOTS = 32,
    parameter int PW    = 5,
    parameter int CW    = 6,
    parameter int LW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_vld,
    input  lnkq_op_e              commit_kind,
    input  logic [LW-1:0]         commit_list,
    input  logic [PW-1:0]         commit_slot,
    input  logic [PW-1:0]         commit_link,
    output logic [NL-1:0][PW-1:0] view_hd,
    output logic [NL-1:0][PW-1:0] view_tl,
    output logic [NL-1:0][CW-1:0] view_cnt
);

    localparam logic [LW-1:0] FREE = LW'(NL - 1);

    logic [NL-1:0][PW-1:0] hd_q, hd_n;
    logic [NL-1:0][PW-1:0] tl_q, tl_n;
    logic [NL-1:0][CW-1:0] cnt_q, cnt_n;

    // Next-state: apply the committed store or remove to its two lists.
    always_comb begin
        hd_n  = hd_q;
        tl_n  = tl_q;
        cnt_n = cnt_q;
        if (commit_vld) begin
            if (commit_kind == OP_ENQ) begin
                if (cnt_q[commit_list] == '0) begin
                    hd_n[commit_list] = commit_slot;
                end
                tl_n[commit_list]  = commit_slot;
                cnt_n[commit_list] = cnt_q[commit_list] + CW'(1);
                hd_n[FREE]         = commit_link;
                cnt_n[FREE]        = cnt_q[FREE] - CW'(1);
            end else begin
                hd_n[commit_list]  = commit_link;
                cnt_n[commit_list] = cnt_q[commit_list] - CW'(1);
                if (cnt_q[FREE] == '0) begin
                    hd_n[FREE] = commit_slot;
                end
                tl_n[FREE]  = commit_slot;
                cnt_n[FREE] = cnt_q[FREE] + CW'(1);
            end
        end
    end

    // Bypassed view for the lookup stage.
    always_comb begin
        view_hd  = hd_n;
        view_tl  = tl_n;
        view_cnt = cnt_n;
    end

    // Table registers: output lists empty, pool holds every slot at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin
                hd_q[i]  <= '0;
                tl_q[i]  <= '0;
                cnt_q[i] <= '0;
            end
            tl_q[FREE]  <= PW'(SLOTS - 1);
            cnt_q[FREE] <= CW'(SLOTS);
        end else begin
            hd_q  <= hd_n;
            tl_q  <= tl_n;
            cnt_q <= cnt_n;
        end
    end

    int total;

    // Occupancy sum across all lists, used by the conservation check.
    always_comb begin
        total = 0;
        for (int i = 0; i < NL; i++) begin
            total += int'(cnt_q[i]);
        end
    end

    // R10: every slot belongs to exactly one list at all times.
    a_r10_slots_conserved: assert property (@(posedge clk) disable iff (!rst_n)
        total == SLOTS);

    // R7: a committed store always finds an unused slot.
    a_r7_store_has_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && commit_kind == OP_ENQ) |-> (cnt_q[FREE] != '0));

    // R8: a committed remove always finds an item.
    a_r8_remove_has_item: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && commit_kind == OP_DEQ) |-> (cnt_q[commit_list] != '0));

endmodule

// File: rtl/lnkq_mgr.sv
// Module: linked-list multi-queue manager (top). Stage 1 looks up the list
// pointers through the bypassed table view and decides refusal; stage 2
// accesses slot memory, commits the pointer update and registers the response.
// Assumes: a requester that holds a request while req_ready is low.
module lnkq_mgr
    import lnkq_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int SLOTS   = 32,
    parameter int DW      = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_deq,
    input  logic [$clog2(NUM_OUT)-1:0] req_queue,
    input  logic [DW-1:0]              req_data,
    output logic                       req_ready,
    output logic                       resp_valid,
    output logic                       resp_deq,
    output logic                       resp_err,
    output logic [$clog2(NUM_OUT)-1:0] resp_port,
    output logic [DW-1:0]              resp_data
);

    localparam int QW = $clog2(NUM_OUT);
    localparam int PW = $clog2(SLOTS);
    localparam int CW = $clog2(SLOTS + 1);
    localparam int NL = NUM_OUT + 1;
    localparam int LW = $clog2(NL);
    localparam logic [LW-1:0] FREE = LW'(NL - 1);

    typedef struct packed {
        logic          vld;
        lnkq_op_e      kind;
        logic [QW-1:0] q;
        logic          err;
        logic [PW-1:0] slot;
        logic [PW-1:0] tail;
        logic          tail_empty;
        logic [DW-1:0] data;
    } stage2_t;

    lnkq_op_e              op_in;
    logic                  accept;
    logic [LW-1:0]         req_list;
    logic [NL-1:0][PW-1:0] view_hd;
    logic [NL-1:0][PW-1:0] view_tl;
    logic [NL-1:0][CW-1:0] view_cnt;
    logic                  s1_err;
    logic [PW-1:0]         s1_slot;
    logic [PW-1:0]         s1_tail;
    logic                  s1_tail_empty;
    stage2_t               s2_q;
    logic                  commit;
    logic [DW-1:0]         rd_data;
    logic [PW-1:0]         rd_link;

    assign op_in = lnkq_op_e'(req_deq);

    lnkq_issue u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (op_in),
        .req_ready (req_ready),
        .accept    (accept)
    );

    // Stage 1 lookup: source slot, destination tail and refusal from the view.
    always_comb begin
        req_list = LW'(req_queue);
        if (op_in == OP_ENQ) begin
            s1_err        = (view_cnt[FREE] == '0);
            s1_slot       = view_hd[FREE];
            s1_tail       = view_tl[req_list];
            s1_tail_empty = (view_cnt[req_list] == '0);
        end else begin
            s1_err        = (view_cnt[req_list] == '0);
            s1_slot       = view_hd[req_list];
            s1_tail       = view_tl[FREE];
            s1_tail_empty = (view_cnt[FREE] == '0);
        end
    end

    // Stage boundary: capture the accepted operation with its lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_q <= '0;
        end else begin
            s2_q.vld <= accept;
            if (accept) begin
                s2_q.kind       <= op_in;
                s2_q.q          <= req_queue;
                s2_q.err        <= s1_err;
                s2_q.slot       <= s1_slot;
                s2_q.tail       <= s1_tail;
                s2_q.tail_empty <= s1_tail_empty;
                s2_q.data       <= req_data;
            end
        end
    end

    assign commit = s2_q.vld && !s2_q.err;

    lnkq_store #(
        .SLOTS (SLOTS),
        .PW    (PW),
        .DW    (DW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .dat_we    (commit && s2_q.kind == OP_ENQ),
        .dat_addr  (s2_q.slot),
        .dat_wdata (s2_q.data),
        .lnk_we    (commit && !s2_q.tail_empty),
        .lnk_addr  (s2_q.tail),
        .lnk_wdata (s2_q.slot),
        .rd_addr   (s2_q.slot),
        .rd_data   (rd_data),
        .rd_link   (rd_link)
    );

    lnkq_ptrs #(
        .NL    (NL),
        .SLOTS (SLOTS),
        .PW    (PW),
        .CW    (CW),
        .LW    (LW)
    ) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_vld  (commit),
        .commit_kind (s2_q.kind),
        .commit_list (LW'(s2_q.q)),
        .commit_slot (s2_q.slot),
        .commit_link (rd_link),
        .view_hd     (view_hd),
        .view_tl     (view_tl),
        .view_cnt    (view_cnt)
    );

    // Response register: one answer per stage-2 operation, data only for removes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_deq   <= 1'b0;
            resp_err   <= 1'b0;
            resp_port  <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= s2_q.vld;
            resp_deq   <= (s2_q.kind == OP_DEQ);
            resp_err   <= s2_q.err;
            resp_port  <= s2_q.q;
            resp_data  <= (commit && s2_q.kind == OP_DEQ) ? rd_data : '0;
        end
    end

    // R4: an accepted request occupies stage 2 in the next cycle.
    a_r4_accept_to_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> s2_q.vld);

    // R4: a response follows exactly the cycles that had stage 2 occupied.
    a_r4_resp_follows_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        s2_q.vld |=> resp_valid);

    a_r4_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_q.vld |=> !resp_valid);

    // R7/R8: a refused response never carries data.
    a_r8_refusal_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (resp_data == '0));

endmodule

// File: tb/lnkq_mgr_bench.sv
`timescale 1ns/1ps
module lnkq_mgr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_deq = 1'b0;
    logic [1:0]  req_queue = '0;
    logic [63:0] req_data = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_deq;
    logic        resp_err;
    logic [1:0]  resp_port;
    logic [63:0] resp_data;

    always #10 clk = ~clk;

    lnkq_mgr u_lnkq_mgr (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_deq    (req_deq),
        .req_queue  (req_queue),
        .req_data   (req_data),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_deq   (resp_deq),
        .resp_err   (resp_err),
        .resp_port  (resp_port),
        .resp_data  (resp_data)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    string tag = "R1";

    // Reference model: per-queue circular buffers and the unused-pool count.
    logic [63:0] mdat [4][32];
    int mrd [4];
    int mcnt [4];
    int fcnt;

    // Expected-response delay line, two entries.
    bit e0_v, e0_d, e0_e, e1_v, e1_d, e1_e;
    logic [1:0] e0_p, e1_p;
    logic [63:0] e0_x, e1_x;
    bit prev_acc, prev_deq;

    task automatic check(input bit ok, input string rq, input logic [67:0] act, input logic [67:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s (%s) actual=%h expected=%h", rq, tag, act, exp);
        end
    endtask

    // One falling-edge step: check due response, drive, model, advance a cycle.
    task automatic step(input bit v, input bit d, input int q, input logic [63:0] dat, output bit acc);
        logic [67:0] act, exp;
        bit exp_rdy;
        act = {resp_valid, resp_deq, resp_err, resp_port, resp_data[62:0]};
        exp = {e1_v, e1_d, e1_e, e1_p, e1_x[62:0]};
        if (!e1_v)
            check(resp_valid == 1'b0, "R4", act, exp);
        else if (e1_e)
            check(act == exp && resp_data[63] == e1_x[63], e1_d ? "R8" : "R7", act, exp);
        else
            check(act == exp && resp_data[63] == e1_x[63], e1_d ? "R3" : "R2", act, exp);
        e1_v = e0_v; e1_d = e0_d; e1_e = e0_e; e1_p = e0_p; e1_x = e0_x;
        e0_v = 1'b0;
        req_valid = v; req_deq = d; req_queue = 2'(q); req_data = dat;
        #1;
        exp_rdy = !(prev_acc && prev_deq == d);
        check(req_ready == exp_rdy, exp_rdy ? "R6" : "R5", 68'(req_ready), 68'(exp_rdy));
        acc = v && exp_rdy;
        if (acc) begin
            e0_v = 1'b1; e0_d = d; e0_p = 2'(q); e0_x = '0;
            if (!d) begin
                e0_e = (fcnt == 0);
                if (!e0_e) begin
                    mdat[q][(mrd[q] + mcnt[q]) % 32] = dat;
                    mcnt[q]++;
                    fcnt--;
                end
            end else begin
                e0_e = (mcnt[q] == 0);
                if (!e0_e) begin
                    e0_x = mdat[q][mrd[q]];
                    mrd[q] = (mrd[q] + 1) % 32;
                    mcnt[q]--;
                    fcnt++;
                end
            end
        end
        prev_acc = acc;
        if (acc) prev_deq = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic op_wait(input bit d, input int q, input logic [63:0] dat);
        bit acc;
        acc = 1'b0;
        while (!acc) step(1'b1, d, q, dat, acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, '0, acc);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit acc;
        logic [31:0] lf;
        bit lastk;
        for (int i = 0; i < 4; i++) begin mrd[i] = 0; mcnt[i] = 0; end
        fcnt = 32;
        e0_v = 0; e1_v = 0; prev_acc = 0; prev_deq = 0;
        e0_d = 0; e0_e = 0; e0_p = 0; e0_x = 0;
        e1_d = 0; e1_e = 0; e1_p = 0; e1_x = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports.
        check(resp_valid == 1'b0, "R1", 68'(resp_valid), 68'(0));
        check(req_ready == 1'b1, "R1", 68'(req_ready), 68'(1));
        @(negedge clk);

        // R1/R8: every output queue starts empty.
        tag = "R8";
        for (int q = 0; q < 4; q++) op_wait(1'b1, q, '0);

        // R12: store then remove on an empty queue, back to back.
        tag = "R12";
        op_wait(1'b0, 2, 64'hA5A5_0000_1234_5678);
        op_wait(1'b1, 2, '0);

        // R5: a repeated kind is held for one cycle.
        tag = "R5";
        op_wait(1'b0, 1, 64'h1111);
        op_wait(1'b0, 1, 64'h2222);
        op_wait(1'b1, 1, '0);
        op_wait(1'b1, 1, '0);

        // R1/R7: fill the pool across all queues, then one store too many.
        tag = "R7";
        for (int i = 0; i < 32; i++) op_wait(1'b0, i % 4, {32'hF00D_0000, 32'(i)});
        op_wait(1'b0, 3, 64'hDEAD);
        op_wait(1'b1, 0, '0);
        op_wait(1'b0, 0, 64'hBEEF);

        // R3/R11/R9: drain every queue in order, then remove from empty.
        tag = "R9";
        for (int q = 0; q < 4; q++) begin
            while (mcnt[q] > 0) op_wait(1'b1, q, '0);
            op_wait(1'b1, q, '0);
        end

        // R10: recycled slots give full capacity again.
        tag = "R10";
        for (int i = 0; i < 33; i++) op_wait(1'b0, (i * 3) % 4, {32'hC0DE_0000, 32'(i)});
        for (int q = 0; q < 4; q++) while (mcnt[q] > 0) op_wait(1'b1, q, '0);

        // R6: strict alternation keeps ready high every cycle.
        tag = "R6";
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b0, i % 4, {32'h6666_0000, 32'(i)}, acc);
            step(1'b1, 1'b1, i % 4, '0, acc);
        end

        // R11: pseudo-random sweep of kinds, queues and idle cycles.
        tag = "R11";
        lf = 32'h1D2C_3B4A;
        lastk = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            bit k;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            k = (lf[2:0] == 3'd0) ? lf[3] : !lastk;
            step(lf[7:6] != 2'd0, k, int'(lf[5:4]), {lf, 32'(i)}, acc);
            if (acc) lastk = k;
        end
        idle(3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule